// File: doc/BRIEF.md
# LCD panel timing generator

The block drives the scan timing of a TFT panel. It gets four packed configuration words: horizontal, vertical, clock/polarity and line-end. It also gets a power request, and it returns everything a panel needs to frame the pixel stream. The outputs are a pixel-rate clock enable, a divided panel clock level, horizontal and vertical sync, data-enable, a delayed line-end pulse and the x/y position of the current active pixel. A fetch engine elsewhere consumes the enable, the position and the data-enable to feed pixel data to the panel.

Each line is scanned as sync, back porch, active, front porch. Each frame is scanned the same way in lines. All timing, divisor and polarity settings are copied into a shadow set when the block is idle and again at every frame boundary, so software may rewrite the words at any time. The power request is sequenced: the timing controller starts before panel power is applied, and panel power is removed before the controller stops.

Top module: `lcd_panel_timing`

## Requirements
- R1: Horizontal word decode. Bits [7:0] hold hsync length minus one. Bits [15:8] hold back porch minus one. Bits [23:16] hold front porch minus one. Bits [29:24] hold (active width / 16) minus one. All counts are in pixel clocks.
- R2: Vertical word decode. Bits [9:0] hold active lines minus one. Bits [15:10] hold vsync lines minus one. Bits [23:16] hold back porch lines and bits [31:24] hold front porch lines; both porch fields are direct counts and may be zero.
- R3: A line is scanned as sync, then back porch, then active, then front porch, and a frame is scanned in lines in the same order. hsync is active for the first hsync-length pixels of every line. vsync is active for the first vsync-length lines of every frame.
- R4: Data-enable is active only when both the pixel and the line are inside their active regions. pix_x and pix_y then give the offset from the first active pixel and line; otherwise both read 0.
- R5: Clock word bits [4:0] hold a divisor value D and bit 5 selects bypass. pix_ce pulses once every D+2 source clocks. In bypass it is high on every source clock while running.
- R6: When not in bypass, panel_clk is high for the first floor((D+2)/2) source clocks of each pixel period and low for the rest. In bypass, or when not running, it is low. Clock word bit 8 inverts it.
- R7: Clock word bit 6 inverts vsync, bit 7 inverts hsync and bit 9 makes data-enable active-low. With a bit at 0 the signal is active-high and idles low.
- R8: Line-end word bit 7 enables line_end and bits [6:0] hold a delay L minus one. line_end is high for exactly one source clock, L source clocks after the clock edge that ends the last active pixel of an active line. With bit 7 at 0 it never pulses.
- R9: When pwr_req rises, ctrl_en rises on the next clock. panel_pwr follows exactly PWR_GAP clocks after ctrl_en.
- R10: When pwr_req falls, panel_pwr drops on the next clock. ctrl_en drops exactly PWR_GAP clocks later. A power-down once begun always completes. A request dropped during power-up goes straight to power-down.
- R11: While running, a change of any configuration word has no effect until the clock edge that ends the last pixel of the frame. The whole new set takes effect together from the first pixel of the next frame.
- R12: During reset and after it until pwr_req rises, ctrl_en, panel_pwr, pix_ce, line_end, pix_x and pix_y are 0. hsync, vsync, data-enable and panel_clk sit at the idle level their invert bits give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Request to run the panel |
| horiz_word | input | 30 | Horizontal timing word |
| vert_word | input | 32 | Vertical timing word |
| clk_word | input | 10 | Divisor, bypass and polarity word |
| lend_word | input | 8 | Line-end enable and delay word |
| ctrl_en | output | 1 | Timing controller running |
| panel_pwr | output | 1 | Panel power enable |
| pix_ce | output | 1 | One-cycle pixel clock enable |
| panel_clk | output | 1 | Divided panel clock level |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| line_end | output | 1 | Delayed line-end pulse |
| pix_x | output | 10 | Active pixel column |
| pix_y | output | 10 | Active line row |

## Verification
A corrupted pixel or line counter shows as a shifted sync or data-enable edge, or a wrong pix_x/pix_y, within one pixel period. A slipped divider count moves pix_ce and the panel_clk phase on the next source clock. A shadow set loaded at the wrong moment changes sync widths or polarity in the middle of a frame. This appears before the frame ends, while the unchanged inputs still predict the old timing. A power sequencer in the wrong state moves the ctrl_en or panel_pwr edge by at least one clock against the fixed PWR_GAP spacing.

// File: rtl/lpt_pkg.sv
// Shared field layout, widths and the configuration record for the LCD
// panel timing generator. Assumes the word layouts stated in the brief.
package lpt_pkg;
    localparam int HPORCH_W = 8;
    localparam int PPL_W    = 6;
    localparam int LINES_W  = 10;
    localparam int VSW_W    = 6;
    localparam int VPORCH_W = 8;
    localparam int PCD_W    = 5;
    localparam int DLY_W    = 7;
    localparam int CNT_W    = 12;
    localparam int X_W      = PPL_W + 4;
    localparam int Y_W      = LINES_W;

    localparam int H_SYNC_LSB  = 0;
    localparam int H_BACK_LSB  = H_SYNC_LSB + HPORCH_W;
    localparam int H_FRONT_LSB = H_BACK_LSB + HPORCH_W;
    localparam int H_PPL_LSB   = H_FRONT_LSB + HPORCH_W;
    localparam int H_WORD_W    = H_PPL_LSB + PPL_W;

    localparam int V_LINES_LSB = 0;
    localparam int V_SYNC_LSB  = V_LINES_LSB + LINES_W;
    localparam int V_BACK_LSB  = V_SYNC_LSB + VSW_W;
    localparam int V_FRONT_LSB = V_BACK_LSB + VPORCH_W;
    localparam int V_WORD_W    = V_FRONT_LSB + VPORCH_W;

    localparam int C_PCD_LSB = 0;
    localparam int C_BYP_BIT = PCD_W;
    localparam int C_INV_V   = C_BYP_BIT + 1;
    localparam int C_INV_H   = C_BYP_BIT + 2;
    localparam int C_INV_CLK = C_BYP_BIT + 3;
    localparam int C_DE_LOW  = C_BYP_BIT + 4;
    localparam int C_WORD_W  = C_DE_LOW + 1;

    localparam int L_DLY_LSB = 0;
    localparam int L_EN_BIT  = DLY_W;
    localparam int L_WORD_W  = L_EN_BIT + 1;

    typedef struct packed {
        logic [CNT_W-1:0] h_sync;
        logic [CNT_W-1:0] h_back;
        logic [CNT_W-1:0] h_act;
        logic [CNT_W-1:0] h_front;
        logic [CNT_W-1:0] v_sync;
        logic [CNT_W-1:0] v_back;
        logic [CNT_W-1:0] v_act;
        logic [CNT_W-1:0] v_front;
        logic [PCD_W-1:0] pcd;
        logic             bypass;
        logic             inv_v;
        logic             inv_h;
        logic             inv_clk;
        logic             de_low;
        logic             le_en;
        logic [DLY_W-1:0] le_dly;
    } lpt_cfg_t;

    // Unpacks the four words into real counts (minus-one fields restored).
    function automatic lpt_cfg_t lpt_decode(
        input logic [H_WORD_W-1:0] hw,
        input logic [V_WORD_W-1:0] vw,
        input logic [C_WORD_W-1:0] cw,
        input logic [L_WORD_W-1:0] lw
    );
        lpt_cfg_t c;
        c.h_sync  = CNT_W'(hw[H_SYNC_LSB +: HPORCH_W]) + CNT_W'(1);
        c.h_back  = CNT_W'(hw[H_BACK_LSB +: HPORCH_W]) + CNT_W'(1);
        c.h_front = CNT_W'(hw[H_FRONT_LSB +: HPORCH_W]) + CNT_W'(1);
        c.h_act   = CNT_W'({hw[H_PPL_LSB +: PPL_W], 4'b0000}) + CNT_W'(16);
        c.v_act   = CNT_W'(vw[V_LINES_LSB +: LINES_W]) + CNT_W'(1);
        c.v_sync  = CNT_W'(vw[V_SYNC_LSB +: VSW_W]) + CNT_W'(1);
        c.v_back  = CNT_W'(vw[V_BACK_LSB +: VPORCH_W]);
        c.v_front = CNT_W'(vw[V_FRONT_LSB +: VPORCH_W]);
        c.pcd     = cw[C_PCD_LSB +: PCD_W];
        c.bypass  = cw[C_BYP_BIT];
        c.inv_v   = cw[C_INV_V];
        c.inv_h   = cw[C_INV_H];
        c.inv_clk = cw[C_INV_CLK];
        c.de_low  = cw[C_DE_LOW];
        c.le_en   = lw[L_EN_BIT];
        c.le_dly  = lw[L_DLY_LSB +: DLY_W];
        return c;
    endfunction
endpackage

// File: rtl/lpt_pwr_seq.sv
// Power sequencer: brings the controller up before panel power and takes
// panel power down before the controller, GAP clocks apart. Assumes GAP >= 1.
module lpt_pwr_seq #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ctrl_en,
    output logic panel_pwr
);
    localparam int GW = $clog2(GAP + 1);

    typedef enum logic [1:0] {PS_OFF, PS_UP, PS_ON, PS_DOWN} ps_t;
    ps_t           st;
    logic [GW-1:0] cnt;

    // Walk OFF -> UP -> ON -> DOWN -> OFF, timing the gaps with cnt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PS_OFF;
            cnt <= '0;
        end else begin
            case (st)
                PS_OFF: begin
                    cnt <= '0;
                    if (req) st <= PS_UP;
                end
                PS_UP: begin
                    if (!req) begin
                        st  <= PS_DOWN;
                        cnt <= '0;
                    end else if (cnt == GW'(GAP - 1)) begin
                        st  <= PS_ON;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + GW'(1);
                    end
                end
                PS_ON: begin
                    cnt <= '0;
                    if (!req) st <= PS_DOWN;
                end
                default: begin
                    if (cnt == GW'(GAP - 1)) begin
                        st  <= PS_OFF;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + GW'(1);
                    end
                end
            endcase
        end
    end

    assign ctrl_en   = (st != PS_OFF);
    assign panel_pwr = (st == PS_ON);
endmodule

// File: rtl/lpt_clk_div.sv
// Pixel clock divider: one-cycle enable every pcd+2 source clocks, or every
// clock in bypass, plus a panel clock level with selectable polarity.
// Assumes pcd/bypass change only at the edge that also issues pix_ce.
module lpt_clk_div #(
    parameter int PCD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PCD_W-1:0] pcd,
    input  logic             bypass,
    input  logic             inv_clk,
    output logic             pix_ce,
    output logic             panel_clk
);
    localparam int DIV_W = PCD_W + 1;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] half;

    assign last = DIV_W'(pcd) + DIV_W'(1);
    assign half = (DIV_W'(pcd) + DIV_W'(2)) >> 1;

    assign pix_ce    = run && (bypass || (cnt == last));
    assign panel_clk = (run && !bypass && (cnt < half)) ^ inv_clk;

    // Count source clocks within the current pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || pix_ce)   cnt <= '0;
        else                       cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/lpt_cfg_shadow.sv
// Shadow copy of the decoded configuration: follows the inputs while idle
// and reloads only at the edge that closes a frame while running.
module lpt_cfg_shadow
    import lpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     frame_wrap,
    input  lpt_cfg_t cfg_in,
    output lpt_cfg_t cfg_q
);
    // Capture the live configuration at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cfg_q <= '0;
        else if (!run || frame_wrap)   cfg_q <= cfg_in;
    end
endmodule

// File: rtl/lpt_scan.sv
// Pixel/line scanner: counts pixels and lines through sync, back porch,
// active and front porch, and derives sync, data-enable and position.
// Assumes every region length comes from the shadow set and totals < 2**CNT_W.
module lpt_scan
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pix_ce,
    input  logic [CNT_W-1:0] h_sync,
    input  logic [CNT_W-1:0] h_back,
    input  logic [CNT_W-1:0] h_act,
    input  logic [CNT_W-1:0] h_front,
    input  logic [CNT_W-1:0] v_sync,
    input  logic [CNT_W-1:0] v_back,
    input  logic [CNT_W-1:0] v_act,
    input  logic [CNT_W-1:0] v_front,
    input  logic             inv_h,
    input  logic             inv_v,
    input  logic             de_low,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [X_W-1:0]   pix_x,
    output logic [Y_W-1:0]   pix_y,
    output logic             frame_wrap,
    output logic             last_act
);
    logic [CNT_W-1:0] h, v;
    logic [CNT_W-1:0] h_start, h_end, h_tot;
    logic [CNT_W-1:0] v_start, v_end, v_tot;
    logic             line_wrap, h_in, v_in, act;

    assign h_start = h_sync + h_back;
    assign h_end   = h_start + h_act;
    assign h_tot   = h_end + h_front;
    assign v_start = v_sync + v_back;
    assign v_end   = v_start + v_act;
    assign v_tot   = v_end + v_front;

    assign line_wrap  = pix_ce && (h == h_tot - CNT_W'(1));
    assign frame_wrap = line_wrap && (v == v_tot - CNT_W'(1));

    // Advance the pixel and line counters on each pixel enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h <= '0;
            v <= '0;
        end else if (pix_ce) begin
            if (line_wrap) begin
                h <= '0;
                v <= frame_wrap ? '0 : v + CNT_W'(1);
            end else begin
                h <= h + CNT_W'(1);
            end
        end
    end

    assign h_in = (h >= h_start) && (h < h_end);
    assign v_in = (v >= v_start) && (v < v_end);
    assign act  = run && h_in && v_in;

    assign hsync    = (run && (h < h_sync)) ^ inv_h;
    assign vsync    = (run && (v < v_sync)) ^ inv_v;
    assign de       = act ^ de_low;
    assign pix_x    = act ? X_W'(h - h_start) : '0;
    assign pix_y    = act ? Y_W'(v - v_start) : '0;
    assign last_act = pix_ce && act && (h == h_end - CNT_W'(1));
endmodule

// File: rtl/lpt_line_end.sv
// Delayed line-end pulse: one clock high, dly+1 clocks after the edge that
// ends the last active pixel of a line. Cleared while the block is idle.
module lpt_line_end #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             trig,
    input  logic             en,
    input  logic [DLY_W-1:0] dly,
    output logic             line_end
);
    logic [DLY_W:0] cnt;

    // Load the delay on a trigger, then count down to the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt <= '0;
        else if (trig && en)   cnt <= {1'b0, dly} + (DLY_W+1)'(1);
        else if (cnt != '0)    cnt <= cnt - (DLY_W+1)'(1);
    end

    assign line_end = (cnt == (DLY_W+1)'(1));
endmodule

// File: rtl/lcd_panel_timing.sv
// Top of the LCD panel timing generator: decodes the four configuration
// words, shadows them per frame, divides the pixel clock, scans the panel
// and sequences power. Outputs are combinational from registered state.
module lcd_panel_timing
    import lpt_pkg::*;
#(
    parameter int PWR_GAP = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_req,
    input  logic [H_WORD_W-1:0] horiz_word,
    input  logic [V_WORD_W-1:0] vert_word,
    input  logic [C_WORD_W-1:0] clk_word,
    input  logic [L_WORD_W-1:0] lend_word,
    output logic                ctrl_en,
    output logic                panel_pwr,
    output logic                pix_ce,
    output logic                panel_clk,
    output logic                hsync,
    output logic                vsync,
    output logic                de,
    output logic                line_end,
    output logic [X_W-1:0]      pix_x,
    output logic [Y_W-1:0]      pix_y
);
    lpt_cfg_t cfg_in, cfg_q;
    logic     frame_wrap, last_act;

    assign cfg_in = lpt_decode(horiz_word, vert_word, clk_word, lend_word);

    lpt_pwr_seq #(.GAP(PWR_GAP)) u_pwr (
        .clk(clk), .rst_n(rst_n), .req(pwr_req),
        .ctrl_en(ctrl_en), .panel_pwr(panel_pwr)
    );

    lpt_cfg_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en), .frame_wrap(frame_wrap),
        .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    lpt_clk_div #(.PCD_W(PCD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en),
        .pcd(cfg_q.pcd), .bypass(cfg_q.bypass), .inv_clk(cfg_q.inv_clk),
        .pix_ce(pix_ce), .panel_clk(panel_clk)
    );

    lpt_scan u_scan (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en), .pix_ce(pix_ce),
        .h_sync(cfg_q.h_sync), .h_back(cfg_q.h_back),
        .h_act(cfg_q.h_act), .h_front(cfg_q.h_front),
        .v_sync(cfg_q.v_sync), .v_back(cfg_q.v_back),
        .v_act(cfg_q.v_act), .v_front(cfg_q.v_front),
        .inv_h(cfg_q.inv_h), .inv_v(cfg_q.inv_v), .de_low(cfg_q.de_low),
        .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y),
        .frame_wrap(frame_wrap), .last_act(last_act)
    );

    lpt_line_end #(.DLY_W(DLY_W)) u_lend (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en), .trig(last_act),
        .en(cfg_q.le_en), .dly(cfg_q.le_dly), .line_end(line_end)
    );
endmodule

// File: rtl/lpt_timing_chk.sv
// Property checker for lcd_panel_timing, bound to every instance.
module lpt_timing_chk
    import lpt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             panel_pwr,
    input logic             pix_ce,
    input logic             bypass_q,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic             inv_h_q,
    input logic             inv_v_q,
    input logic             de_low_q,
    input logic             line_end,
    input logic [X_W-1:0]   pix_x,
    input logic [CNT_W-1:0] h_act_q
);
    logic de_on;
    assign de_on = de ^ de_low_q;

    // R9
    pwr_up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_pwr) |-> $past(ctrl_en));

    // R10
    pwr_down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_en) |-> !$past(panel_pwr));

    // R5
    pix_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && !bypass_q) |=> (!pix_ce || bypass_q));

    // R4
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_on |-> (!(hsync ^ inv_h_q) && !(vsync ^ inv_v_q)));

    // R4
    x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_on |-> (CNT_W'(pix_x) < h_act_q));

    // R8
    lend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (!pix_ce && !panel_pwr && !de_on));
endmodule

bind lcd_panel_timing lpt_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .panel_pwr(panel_pwr),
    .pix_ce(pix_ce), .bypass_q(cfg_q.bypass), .hsync(hsync), .vsync(vsync),
    .de(de), .inv_h_q(cfg_q.inv_h), .inv_v_q(cfg_q.inv_v),
    .de_low_q(cfg_q.de_low), .line_end(line_end), .pix_x(pix_x),
    .h_act_q(cfg_q.h_act)
);

// File: tb/lcd_panel_timing_test.sv
`timescale 1ns/1ps
module lcd_panel_timing_test;
    localparam int GAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_req = 1'b0;
    logic [29:0] horiz_word = '0;
    logic [31:0] vert_word = '0;
    logic [9:0]  clk_word = '0;
    logic [7:0]  lend_word = '0;
    logic        ctrl_en, panel_pwr, pix_ce, panel_clk, hsync, vsync, de, line_end;
    logic [9:0]  pix_x, pix_y;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R12";

    // model state
    int m_st, m_pc, m_div, m_h, m_v, m_le;
    int c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;
    int c_pcd, c_byp, c_iv, c_ih, c_ic, c_dl, c_le, c_dly;

    always #2 clk = ~clk;

    lcd_panel_timing #(.PWR_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
        .horiz_word(horiz_word), .vert_word(vert_word),
        .clk_word(clk_word), .lend_word(lend_word),
        .ctrl_en(ctrl_en), .panel_pwr(panel_pwr), .pix_ce(pix_ce),
        .panel_clk(panel_clk), .hsync(hsync), .vsync(vsync), .de(de),
        .line_end(line_end), .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", phase, what, $time, act, exp);
        end
    endtask

    // Field decode per R1, R2, R5..R8
    task automatic load_cfg();
        c_hs  = horiz_word[7:0] + 1;
        c_hb  = horiz_word[15:8] + 1;
        c_hf  = horiz_word[23:16] + 1;
        c_ha  = (horiz_word[29:24] + 1) * 16;
        c_va  = vert_word[9:0] + 1;
        c_vs  = vert_word[15:10] + 1;
        c_vb  = vert_word[23:16];
        c_vf  = vert_word[31:24];
        c_pcd = clk_word[4:0];
        c_byp = clk_word[5];
        c_iv  = clk_word[6];
        c_ih  = clk_word[7];
        c_ic  = clk_word[8];
        c_dl  = clk_word[9];
        c_dly = lend_word[6:0];
        c_le  = lend_word[7];
    endtask

    function automatic int active_now();
        int hs0 = c_hs + c_hb;
        int vs0 = c_vs + c_vb;
        return int'(m_st != 0 && m_h >= hs0 && m_h < hs0 + c_ha && m_v >= vs0 && m_v < vs0 + c_va);
    endfunction

    function automatic int pix_now();
        return int'(m_st != 0 && (c_byp != 0 || m_div == c_pcd + 1));
    endfunction

    task automatic compare();
        int run = int'(m_st != 0);
        int act = active_now();
        chk("R9 ctrl_en", int'(ctrl_en), run);
        chk("R10 panel_pwr", int'(panel_pwr), int'(m_st == 2));
        chk("R5 pix_ce", int'(pix_ce), pix_now());
        chk("R6 panel_clk", int'(panel_clk),
            int'(run != 0 && c_byp == 0 && m_div < (c_pcd + 2) / 2) ^ c_ic);
        chk("R1 R3 R7 hsync", int'(hsync), int'(run != 0 && m_h < c_hs) ^ c_ih);
        chk("R2 R3 R7 vsync", int'(vsync), int'(run != 0 && m_v < c_vs) ^ c_iv);
        chk("R4 R7 de", int'(de), act ^ c_dl);
        chk("R4 pix_x", int'(pix_x), act != 0 ? m_h - c_hs - c_hb : 0);
        chk("R4 pix_y", int'(pix_y), act != 0 ? m_v - c_vs - c_vb : 0);
        chk("R8 line_end", int'(line_end), int'(m_le == 1));
    endtask

    // Predict the state after the next clock edge from the current inputs.
    task automatic model_step();
        int run, pix, act, htot, vtot, lwrap, fwrap;
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_div = 0; m_h = 0; m_v = 0; m_le = 0;
            c_hs = 0; c_hb = 0; c_ha = 0; c_hf = 0; c_vs = 0; c_vb = 0; c_va = 0; c_vf = 0;
            c_pcd = 0; c_byp = 0; c_iv = 0; c_ih = 0; c_ic = 0; c_dl = 0; c_le = 0; c_dly = 0;
            return;
        end
        run   = int'(m_st != 0);
        pix   = pix_now();
        act   = active_now();
        htot  = c_hs + c_hb + c_ha + c_hf;
        vtot  = c_vs + c_vb + c_va + c_vf;
        lwrap = int'(pix != 0 && m_h == htot - 1);
        fwrap = int'(lwrap != 0 && m_v == vtot - 1);
        if (run == 0) m_le = 0;
        else if (pix != 0 && act != 0 && m_h == c_hs + c_hb + c_ha - 1 && c_le != 0) m_le = c_dly + 1;
        else if (m_le != 0) m_le--;
        if (run == 0) begin
            m_h = 0; m_v = 0; m_div = 0;
        end else if (pix != 0) begin
            m_div = 0;
            if (lwrap != 0) begin
                m_h = 0;
                m_v = (fwrap != 0) ? 0 : m_v + 1;
            end else m_h++;
        end else m_div++;
        if (run == 0 || fwrap != 0) load_cfg();
        case (m_st)
            0: begin m_pc = 0; if (pwr_req) m_st = 1; end
            1: begin
                if (!pwr_req) begin m_st = 3; m_pc = 0; end
                else if (m_pc == GAP - 1) begin m_st = 2; m_pc = 0; end
                else m_pc++;
            end
            2: begin m_pc = 0; if (!pwr_req) m_st = 3; end
            default: begin
                if (m_pc == GAP - 1) begin m_st = 0; m_pc = 0; end
                else m_pc++;
            end
        endcase
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set_cfg(input int hs, hb, hf, ppl, ln, vs, vb, vf,
                           input int pcd, byp, iv, ih, ic, dl, le, dly);
        horiz_word = {ppl[5:0], hf[7:0], hb[7:0], hs[7:0]};
        vert_word  = {vf[7:0], vb[7:0], vs[5:0], ln[9:0]};
        clk_word   = {dl[0], ic[0], ih[0], iv[0], byp[0], pcd[4:0]};
        lend_word  = {le[0], dly[6:0]};
    endtask

    function automatic int frame_cycles(input int hs, hb, hf, ppl, ln, vs, vb, vf, pcd, byp);
        return ((ppl + 1) * 16 + hs + hb + hf + 3) * (ln + vs + vb + vf + 2) * (byp != 0 ? 1 : pcd + 2);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hs, hb, hf, ppl, ln, vs, vb, vf, pcd, byp;
        void'($urandom(32'd20240611));
        // R12: reset and idle state with a configuration on the inputs
        set_cfg(1, 2, 0, 0, 3, 0, 1, 1, 0, 0, 0, 0, 0, 0, 1, 2);
        tick(4);
        rst_n = 1'b1;
        tick(6);
        // R9: power-up, then two frames of the divided configuration
        phase = "R9 R1 R2";
        pwr_req = 1'b1;
        tick(2 * frame_cycles(1, 2, 0, 0, 3, 0, 1, 1, 0, 0));
        // R11: mid-frame change to bypass, inverted, zero vertical porches
        phase = "R11";
        tick(37);
        set_cfg(0, 0, 2, 1, 1, 2, 0, 0, 3, 1, 1, 1, 1, 1, 0, 5);
        tick(2 * frame_cycles(0, 0, 2, 1, 1, 2, 0, 0, 3, 1));
        // random configurations, each switched in mid-frame
        phase = "random";
        for (int k = 0; k < 10; k++) begin
            hs = $urandom_range(2); hb = $urandom_range(2); hf = $urandom_range(2);
            ppl = $urandom_range(1); ln = $urandom_range(3); vs = $urandom_range(1);
            vb = $urandom_range(2); vf = $urandom_range(2); pcd = $urandom_range(3);
            byp = ($urandom_range(3) == 0) ? 1 : 0;
            set_cfg(hs, hb, hf, ppl, ln, vs, vb, vf, pcd, byp,
                    $urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(1), $urandom_range(1), $urandom_range(9));
            tick(2 * frame_cycles(hs, hb, hf, ppl, ln, vs, vb, vf, pcd, byp) + $urandom_range(40));
        end
        // R10: power-down, aborted power-up, then restart
        phase = "R10";
        pwr_req = 1'b0;
        tick(GAP + 12);
        pwr_req = 1'b1;
        tick(3);
        pwr_req = 1'b0;
        tick(GAP + 10);
        phase = "R9 restart";
        pwr_req = 1'b1;
        tick(GAP + 400);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule